// File: doc/BRIEF.md
# Shifting ALU with Condition Flags

This block is the data-processing datapath of a 32-bit integer core. The second operand first passes through a shifter that can shift left, shift right logically, shift right arithmetically or rotate right by a 5-bit amount. An arithmetic or bitwise operation then combines it with the first operand. The block returns the result, the four condition flags (negative, zero, carry, overflow), a mask that tells the flag register which flags to take, and a write enable for the destination register.

The arithmetic operations take their carry and overflow from the adder. The bitwise operations take their carry from the shifter's carry-out and never touch the overflow flag. The compare and test operations update the flags only and assert no write. Everything is computed combinationally and captured in a single output register stage, so each operation shows at the outputs one clock after it is presented.

Top module: `dp_alu`

## Requirements
- R1: Outputs are registered: an operation presented before a rising edge appears on every output after that edge, and not earlier. Active-low asynchronous reset clears the result, all four flags, the flag mask and the write enable to 0.
- R2: Opcode encoding: 0 AND, 1 XOR, 2 SUB (a-b), 3 RSUB (b-a), 4 ADD, 5 ADDC, 6 SUBC, 7 RSUBC, 8 TESTAND, 9 TESTXOR, 10 CMP, 11 CMPNEG, 12 OR, 13 PASS, 14 ANDN, 15 NOT. Here b always means the shifted second operand. RSUB with a zero second operand returns the negation of a.
- R3: N equals bit 31 of the result, and Z is 1 exactly when the result is zero.
- R4: For addition, C is the unsigned carry out. For subtraction, C is 1 when no borrow occurs (minuend >= subtrahend, unsigned). V is 1 on a signed overflow.
- R5: ADDC computes a+b+C. SUBC computes a-b-NOT(C). RSUBC computes b-a-NOT(C). C is the carry_i input.
- R6: The bitwise results are: AND gives a&b, XOR gives a^b, OR gives a|b, ANDN gives a&~b, PASS gives b, and NOT gives ~b.
- R7: Shift type encoding: 0 logical left, 1 logical right, 2 arithmetic right (fills with bit 31), 3 rotate right. The shift amount is shamt_i, in the range 0 to 31.
- R8: For a nonzero amount n, the shifter carry-out is operand bit [32-n] for a left shift and bit [n-1] for the other three types. An amount of 0 passes the operand through unchanged, and the shifter carry-out equals carry_i.
- R9: For the bitwise operations, C is the shifter carry-out, and V is excluded from the flag mask.
- R10: CMP (a-b), CMPNEG (a+b), TESTAND (a&b) and TESTXOR (a^b) always update their flags, whatever set_flags_i is. They drive wr_en_o to 0. All other opcodes drive wr_en_o to 1.
- R11: When set_flags_i is 0, an opcode that is not a compare or test gives a flag mask of 0.
- R12: Flag mask encoding: bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. The mask is 4'b1111 for arithmetic operations, 4'b1110 for bitwise operations and 4'b0000 when no flags update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode (R2) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, before the shifter |
| shtype_i | input | 2 | Shift type (R7) |
| shamt_i | input | 5 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| set_flags_i | input | 1 | Request a flag update |
| result_o | output | 32 | Result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_upd_o | output | 4 | Flags to update, as {N,Z,C,V} |
| wr_en_o | output | 1 | Write the result to the destination |

## Verification
A shift and a flag-setting operation land in the same cycle whenever the second operand is shifted by a nonzero amount. That cycle decides whether C comes from the shifter or from the adder. Vectors pair bitwise operations that shift a chosen bit into the carry position with arithmetic operations on shifted operands. The carry must follow the shifter in the first case and the adder in the second. A shift amount of 0 combined with carry_i=1 shows that the incoming carry survives the pass-through.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND     = 4'd0,
        OP_XOR     = 4'd1,
        OP_SUB     = 4'd2,
        OP_RSUB    = 4'd3,
        OP_ADD     = 4'd4,
        OP_ADDC    = 4'd5,
        OP_SUBC    = 4'd6,
        OP_RSUBC   = 4'd7,
        OP_TESTAND = 4'd8,
        OP_TESTXOR = 4'd9,
        OP_CMP     = 4'd10,
        OP_CMPNEG  = 4'd11,
        OP_OR      = 4'd12,
        OP_PASS    = 4'd13,
        OP_ANDN    = 4'd14,
        OP_NOT     = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    // flag mask, bit order {N,Z,C,V}
    localparam logic [3:0] MASK_ARITH = 4'b1111;
    localparam logic [3:0] MASK_LOGIC = 4'b1110;
    localparam logic [3:0] MASK_NONE  = 4'b0000;

endpackage

// File: rtl/dp_shifter.sv
module dp_shifter
    import dp_alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SAW = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [1:0]     kind_i,
    input  logic [SAW-1:0] amt_i,
    input  logic           cin_i,
    output logic [W-1:0]   val_o,
    output logic           cout_o
);

    int unsigned n;

    always_comb begin
        n      = int'(amt_i);
        val_o  = val_i;
        cout_o = cin_i;
        if (n != 0) begin
            case (kind_i)
                SH_LSL: begin
                    val_o  = val_i << n;
                    cout_o = val_i[W-n];
                end
                SH_LSR: begin
                    val_o  = val_i >> n;
                    cout_o = val_i[n-1];
                end
                SH_ASR: begin
                    val_o  = $signed(val_i) >>> n;
                    cout_o = val_i[n-1];
                end
                default: begin
                    val_o  = (val_i >> n) | (val_i << (W - n));
                    cout_o = val_i[n-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        // same-sign inputs with a result of the other sign
        ovf_o  = (x_i[W-1] == y_i[W-1]) && (wide[W-1] != x_i[W-1]);
    end

endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);

    always_comb begin
        case (op_i)
            OP_AND, OP_TESTAND: res_o = a_i & b_i;
            OP_XOR, OP_TESTXOR: res_o = a_i ^ b_i;
            OP_OR:              res_o = a_i | b_i;
            OP_ANDN:            res_o = a_i & ~b_i;
            OP_PASS:            res_o = b_i;
            OP_NOT:             res_o = ~b_i;
            default:            res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SAW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [1:0]     shtype_i,
    input  logic [SAW-1:0] shamt_i,
    input  logic           carry_i,
    input  logic           set_flags_i,
    output logic [W-1:0]   result_o,
    output logic           flag_n_o,
    output logic           flag_z_o,
    output logic           flag_c_o,
    output logic           flag_v_o,
    output logic [3:0]     flag_upd_o,
    output logic           wr_en_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         n;
        logic         z;
        logic         c;
        logic         v;
        logic [3:0]   upd;
        logic         wr;
    } stage_t;

    stage_t st_d, st_q;

    logic [W-1:0] b_sh;
    logic         sh_co;
    logic [W-1:0] add_x, add_y, add_sum, log_res;
    logic         add_ci, add_co, add_ov;
    logic         is_arith, is_cmp;

    dp_shifter #(.W(W), .SAW(SAW)) u_shift (
        .val_i  (b_i),
        .kind_i (shtype_i),
        .amt_i  (shamt_i),
        .cin_i  (carry_i),
        .val_o  (b_sh),
        .cout_o (sh_co)
    );

    // operand steering for the shared adder
    always_comb begin
        add_x  = a_i;
        add_y  = b_sh;
        add_ci = 1'b0;
        case (op_i)
            OP_SUB, OP_CMP: begin add_y = ~b_sh; add_ci = 1'b1;    end
            OP_SUBC:        begin add_y = ~b_sh; add_ci = carry_i; end
            OP_RSUB:        begin add_x = b_sh; add_y = ~a_i; add_ci = 1'b1;    end
            OP_RSUBC:       begin add_x = b_sh; add_y = ~a_i; add_ci = carry_i; end
            OP_ADDC:        add_ci = carry_i;
            default:        add_ci = 1'b0;
        endcase
    end

    dp_addsub #(.W(W)) u_add (
        .x_i    (add_x),
        .y_i    (add_y),
        .cin_i  (add_ci),
        .sum_o  (add_sum),
        .cout_o (add_co),
        .ovf_o  (add_ov)
    );

    dp_logic #(.W(W)) u_logic (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_sh),
        .res_o (log_res)
    );

    always_comb begin
        is_arith = op_i inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC,
                                OP_RSUBC, OP_CMP, OP_CMPNEG};
        is_cmp   = op_i inside {OP_TESTAND, OP_TESTXOR, OP_CMP, OP_CMPNEG};
        st_d.res = is_arith ? add_sum : log_res;
        st_d.n   = st_d.res[W-1];
        st_d.z   = (st_d.res == '0);
        st_d.c   = is_arith ? add_co : sh_co;
        st_d.v   = is_arith ? add_ov : 1'b0;
        st_d.wr  = !is_cmp;
        if (is_cmp || set_flags_i)
            st_d.upd = is_arith ? MASK_ARITH : MASK_LOGIC;
        else
            st_d.upd = MASK_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o   = st_q.res;
    assign flag_n_o   = st_q.n;
    assign flag_z_o   = st_q.z;
    assign flag_c_o   = st_q.c;
    assign flag_v_o   = st_q.v;
    assign flag_upd_o = st_q.upd;
    assign wr_en_o    = st_q.wr;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
    import dp_alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SAW = $clog2(W)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     op_i,
    input logic [SAW-1:0] shamt_i,
    input logic           carry_i,
    input logic           set_flags_i,
    input logic [W-1:0]   result_o,
    input logic           flag_n_o,
    input logic           flag_z_o,
    input logic           flag_c_o,
    input logic [3:0]     flag_upd_o,
    input logic           wr_en_o
);

    logic cmp_op, bit_op;
    assign cmp_op = (op_i == OP_TESTAND) || (op_i == OP_TESTXOR) ||
                    (op_i == OP_CMP) || (op_i == OP_CMPNEG);
    assign bit_op = (op_i == OP_AND) || (op_i == OP_XOR) || (op_i == OP_OR) ||
                    (op_i == OP_ANDN) || (op_i == OP_PASS) || (op_i == OP_NOT) ||
                    (op_i == OP_TESTAND) || (op_i == OP_TESTXOR);

    AST_NEG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_o[3] |-> (flag_n_o == result_o[W-1]));                       // R3
    AST_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_o[2] |-> (flag_z_o == (result_o == '0)));                   // R3
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_op |=> (!wr_en_o && flag_upd_o != 4'b0000));                     // R10
    AST_BITOP_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        bit_op |=> !flag_upd_o[0]);                                          // R9
    AST_NO_SET_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags_i && !cmp_op) |=> (flag_upd_o == 4'b0000 && wr_en_o));  // R11
    AST_ZERO_AMT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op && shamt_i == '0) |=> (flag_c_o == $past(carry_i)));         // R8
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_o inside {4'b0000, 4'b1110, 4'b1111});                      // R12

endmodule

bind dp_alu dp_alu_chk #(.W(W), .SAW(SAW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .shamt_i     (shamt_i),
    .carry_i     (carry_i),
    .set_flags_i (set_flags_i),
    .result_o    (result_o),
    .flag_n_o    (flag_n_o),
    .flag_z_o    (flag_z_o),
    .flag_c_o    (flag_c_o),
    .flag_upd_o  (flag_upd_o),
    .wr_en_o     (wr_en_o)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  st;
        logic [4:0]  amt;
        logic        cin;
        logic        s;
        logic [31:0] res;
        logic [3:0]  nzcv;
        logic [3:0]  mask;
        logic        wr;
    } vec_t;

    localparam int NV = 27;
    // op, a, b, shtype, amount, carry, set | result, nzcv, mask, write
    localparam vec_t VEC [NV] = '{
        '{4'd4,  32'h1,        32'h2,        2'd0, 5'd0,  1'b0, 1'b1, 32'h3,        4'b0000, 4'hF, 1'b1}, // R2 add
        '{4'd4,  32'h7FFFFFFF, 32'h1,        2'd0, 5'd0,  1'b0, 1'b1, 32'h80000000, 4'b1001, 4'hF, 1'b1}, // R4 signed ovf
        '{4'd4,  32'hFFFFFFFF, 32'h1,        2'd0, 5'd0,  1'b0, 1'b1, 32'h0,        4'b0110, 4'hF, 1'b1}, // R3 zero, carry
        '{4'd2,  32'h5,        32'h3,        2'd0, 5'd0,  1'b0, 1'b1, 32'h2,        4'b0010, 4'hF, 1'b1}, // R4 no borrow
        '{4'd2,  32'h3,        32'h5,        2'd0, 5'd0,  1'b0, 1'b1, 32'hFFFFFFFE, 4'b1000, 4'hF, 1'b1}, // R4 borrow
        '{4'd2,  32'h80000000, 32'h1,        2'd0, 5'd0,  1'b0, 1'b1, 32'h7FFFFFFF, 4'b0011, 4'hF, 1'b1}, // R4 sub ovf
        '{4'd3,  32'h5,        32'h0,        2'd0, 5'd0,  1'b0, 1'b1, 32'hFFFFFFFB, 4'b1000, 4'hF, 1'b1}, // R2 negate
        '{4'd5,  32'h1,        32'h2,        2'd0, 5'd0,  1'b1, 1'b1, 32'h4,        4'b0000, 4'hF, 1'b1}, // R5 addc
        '{4'd6,  32'h5,        32'h3,        2'd0, 5'd0,  1'b0, 1'b1, 32'h1,        4'b0010, 4'hF, 1'b1}, // R5 subc
        '{4'd0,  32'hF0F0F0F0, 32'hFF00FF00, 2'd0, 5'd0,  1'b1, 1'b1, 32'hF000F000, 4'b1010, 4'hE, 1'b1}, // R9 and
        '{4'd14, 32'hFFFFFFFF, 32'h0000FFFF, 2'd0, 5'd0,  1'b0, 1'b1, 32'hFFFF0000, 4'b1000, 4'hE, 1'b1}, // R6 andn
        '{4'd15, 32'h0,        32'h0,        2'd0, 5'd0,  1'b0, 1'b1, 32'hFFFFFFFF, 4'b1000, 4'hE, 1'b1}, // R6 not
        '{4'd13, 32'h0,        32'h3,        2'd0, 5'd31, 1'b0, 1'b1, 32'h80000000, 4'b1010, 4'hE, 1'b1}, // R8 lsl carry
        '{4'd13, 32'h0,        32'h80000001, 2'd1, 5'd1,  1'b0, 1'b1, 32'h40000000, 4'b0010, 4'hE, 1'b1}, // R8 lsr carry
        '{4'd13, 32'h0,        32'h80000000, 2'd2, 5'd4,  1'b0, 1'b1, 32'hF8000000, 4'b1000, 4'hE, 1'b1}, // R7 asr
        '{4'd13, 32'h0,        32'h0000000F, 2'd3, 5'd4,  1'b0, 1'b1, 32'hF0000000, 4'b1010, 4'hE, 1'b1}, // R7 ror
        '{4'd10, 32'h5,        32'h5,        2'd0, 5'd0,  1'b0, 1'b0, 32'h0,        4'b0110, 4'hF, 1'b0}, // R10 cmp
        '{4'd11, 32'hFFFFFFFF, 32'h1,        2'd0, 5'd0,  1'b0, 1'b0, 32'h0,        4'b0110, 4'hF, 1'b0}, // R10 cmpneg
        '{4'd8,  32'h0F,       32'hF0,       2'd0, 5'd0,  1'b1, 1'b0, 32'h0,        4'b0110, 4'hE, 1'b0}, // R10 testand
        '{4'd4,  32'hFFFFFFFF, 32'h1,        2'd0, 5'd0,  1'b0, 1'b0, 32'h0,        4'b0000, 4'h0, 1'b1}, // R11 no set
        '{4'd13, 32'h0,        32'h1234,     2'd1, 5'd0,  1'b1, 1'b1, 32'h1234,     4'b0010, 4'hE, 1'b1}, // R8 amount 0
        '{4'd4,  32'h1,        32'h1,        2'd0, 5'd4,  1'b0, 1'b1, 32'h11,       4'b0000, 4'hF, 1'b1}, // R7 shifted add
        '{4'd1,  32'hFF,       32'h0F,       2'd0, 5'd0,  1'b0, 1'b1, 32'hF0,       4'b0000, 4'hE, 1'b1}, // R6 xor
        '{4'd12, 32'hF0,       32'h0F,       2'd0, 5'd0,  1'b0, 1'b1, 32'hFF,       4'b0000, 4'hE, 1'b1}, // R6 or
        '{4'd9,  32'hAA,       32'hAA,       2'd0, 5'd0,  1'b0, 1'b0, 32'h0,        4'b0100, 4'hE, 1'b0}, // R10 testxor
        '{4'd7,  32'h3,        32'h5,        2'd0, 5'd0,  1'b0, 1'b1, 32'h1,        4'b0010, 4'hF, 1'b1}, // R5 rsubc
        '{4'd13, 32'h0,        32'h1,        2'd0, 5'd1,  1'b1, 1'b1, 32'h2,        4'b0000, 4'hE, 1'b1}  // R8 carry replaced
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [1:0]  shtype_i = '0;
    logic [4:0]  shamt_i = '0;
    logic        carry_i = 1'b0, set_flags_i = 1'b0;
    logic [31:0] result_o;
    logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o, wr_en_o;
    logic [3:0]  flag_upd_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .shtype_i(shtype_i), .shamt_i(shamt_i), .carry_i(carry_i),
        .set_flags_i(set_flags_i), .result_o(result_o), .flag_n_o(flag_n_o),
        .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o),
        .flag_upd_o(flag_upd_o), .wr_en_o(wr_en_o)
    );

    function automatic string tag_of(int i);
        case (i)
            0, 6:                return "R2";
            2:                   return "R3";
            1, 3, 4, 5:          return "R4";
            7, 8, 25:            return "R5";
            10, 11, 22, 23:      return "R6";
            14, 15, 21:          return "R7";
            12, 13, 20, 26:      return "R8";
            9:                   return "R9";
            16, 17, 18, 24:      return "R10";
            default:             return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i = v.op; a_i = v.a; b_i = v.b; shtype_i = v.st;
        shamt_i = v.amt; carry_i = v.cin; set_flags_i = v.s;
    endtask

    function automatic logic [3:0] flags_now();
        return {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(result_o == '0 && flags_now() == '0 && flag_upd_o == '0 && !wr_en_o,
            "R1", "reset state", {result_o[27:0], flags_now()}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            chk(wr_en_o == VEC[i].wr, tag_of(i), $sformatf("vec %0d write", i),
                32'(wr_en_o), 32'(VEC[i].wr));
            chk(flag_upd_o == VEC[i].mask, tag_of(i), $sformatf("vec %0d mask", i),
                32'(flag_upd_o), 32'(VEC[i].mask));
            if (VEC[i].wr)
                chk(result_o == VEC[i].res, tag_of(i), $sformatf("vec %0d result", i),
                    result_o, VEC[i].res);
            chk((flags_now() & VEC[i].mask) == (VEC[i].nzcv & VEC[i].mask), tag_of(i),
                $sformatf("vec %0d flags", i),
                32'(flags_now() & VEC[i].mask), 32'(VEC[i].nzcv & VEC[i].mask));
        end

        // R1: output holds until the next rising edge
        drive('{4'd4, 32'd10, 32'd20, 2'd0, 5'd0, 1'b0, 1'b1, 32'd0, 4'd0, 4'd0, 1'b0});
        #5;
        chk(result_o == 32'h2, "R1", "hold before edge", result_o, 32'h2);
        @(negedge clk);
        chk(result_o == 32'd30, "R1", "update after edge", result_o, 32'd30);

        // R12: bit positions of the mask for a test op
        drive('{4'd8, 32'h1, 32'h1, 2'd0, 5'd0, 1'b0, 1'b0, 32'd0, 4'd0, 4'd0, 1'b0});
        @(negedge clk);
        chk(flag_upd_o == 4'b1110, "R12", "test mask", 32'(flag_upd_o), 32'hE);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        #3;
        chk(result_o == '0 && flag_upd_o == '0 && !wr_en_o, "R1", "mid-run reset",
            result_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule